// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block sits between the alarm comparators of a real-time clock and its single interrupt pin. Each alarm's comparator supplies a one-cycle match strobe. The block records enabled matches in a per-alarm status flag. It then drives the shared pin in one of two ways. In latched mode the pin stays asserted until the host has cleared every flag. In pulsed mode every match of an enabled alarm produces a fixed-length pulse, and the host does not need to clear anything between matches.

The host reads the status flags directly and clears a flag by writing a 1 to its bit on the clear port. When the frequency output is enabled, the frequency source owns the pin and all alarm pulses are held back. The status flags keep recording matches during that time. The pin is active low by default. The number of alarms and the pulse length are parameters.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset every status flag is 0 and `irq_o` is high (inactive).
- R2: A match on alarm i while `alarm_en_i[i]` is 1 sets `status_o[i]` at the next clock edge. A match while the enable is 0 leaves the flag and the pin unchanged.
- R3: With `pulse_mode_i` = 0 and `fout_en_i` = 0, `irq_o` goes low in the cycle after an enabled match. It stays low for as long as any status flag is set.
- R4: A write with `clr_we_i` = 1 clears every flag whose `clr_mask_i` bit is 1 at the next edge and leaves the flags whose mask bit is 0 alone. In latched mode the pin returns high once no flag remains set.
- R5: If an enabled match and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R6: With `pulse_mode_i` = 1 and `fout_en_i` = 0, each enabled match drives `irq_o` low for exactly PULSE_CYCLES (default 4) cycles, starting in the cycle after the match. Later matches produce further pulses with no clear in between, and the status flags do not hold the pin low.
- R7: In pulsed mode each alarm has its own pulse timer. A new match on one alarm restarts only that alarm's timer, and the pin is low while either timer runs.
- R8: In pulsed mode, clearing an alarm's enable ends that alarm's pulse in the same cycle, and matches no longer produce pulses.
- R9: While `fout_en_i` = 1, `irq_o` equals `fout_wave_i` in the same cycle. Alarm pulses are suppressed and leave no pending pulse behind when the frequency output is turned off. Enabled matches still set the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match_i | input | NUM_ALARMS | One-cycle match strobe per alarm from the comparator |
| alarm_en_i | input | NUM_ALARMS | Per-alarm enable |
| pulse_mode_i | input | 1 | 1 = repeating pulsed mode, 0 = latched single-event mode |
| fout_en_i | input | 1 | Frequency output owns the pin when 1 |
| fout_wave_i | input | 1 | Frequency waveform forwarded to the pin |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | NUM_ALARMS | Write-one-to-clear mask for the status flags |
| status_o | output | NUM_ALARMS | Per-alarm fired flags |
| irq_o | output | 1 | Shared interrupt pin, active low by default |

## Verification
Status flags and pulse timers are registered, so a match or a clear shows up on `status_o` and `irq_o` one edge after it is driven. Gating by the enables, the mode bit or the frequency select is combinational and takes effect in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge, which places each sample exactly one register stage after its stimulus. To check pulse lengths, the bench counts low samples across a window longer than any pulse and compares the count with the expected number of cycles.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   // width of a down-counter that must hold the value n
   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (hit_i)  flag_o <= 1'b1;   // a new hit outranks a clear
      else if (clr_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/rtc_alarm_pulse.sv
module rtc_alarm_pulse
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned PULSE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic run_i,
   output logic active_o
);
   localparam int unsigned CW = cnt_width(PULSE_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run_i)          cnt_q <= '0;
      else if (start_i)         cnt_q <= LOAD;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = run_i && (cnt_q != '0);
endmodule

// File: rtl/rtc_alarm_pin.sv
module rtc_alarm_pin #(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic assert_i,
   input  logic fout_en_i,
   input  logic fout_wave_i,
   output logic pin_o
);
   logic level;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign level = ~assert_i;
      end else begin : g_high
         assign level = assert_i;
      end
   endgenerate

   assign pin_o = fout_en_i ? fout_wave_i : level;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
   parameter int unsigned NUM_ALARMS     = 2,
   parameter int unsigned PULSE_CYCLES   = 4,
   parameter bit          IRQ_ACTIVE_LOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_ALARMS-1:0] match_i,
   input  logic [NUM_ALARMS-1:0] alarm_en_i,
   input  logic                  pulse_mode_i,
   input  logic                  fout_en_i,
   input  logic                  fout_wave_i,
   input  logic                  clr_we_i,
   input  logic [NUM_ALARMS-1:0] clr_mask_i,
   output logic [NUM_ALARMS-1:0] status_o,
   output logic                  irq_o
);
   generate
      if (NUM_ALARMS < 1 || NUM_ALARMS > 8) begin : g_bad_n
         $error("rtc_alarm_irq: NUM_ALARMS must be 1..8");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_p
         $error("rtc_alarm_irq: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic [NUM_ALARMS-1:0] hit;
   logic [NUM_ALARMS-1:0] pulse_act;
   logic                  pulse_ok;
   logic                  want_assert;

   assign hit      = match_i & alarm_en_i;
   assign pulse_ok = pulse_mode_i & ~fout_en_i;

   generate
      for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
         rtc_alarm_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hit[g]),
            .clr_i  (clr_we_i & clr_mask_i[g]),
            .flag_o (status_o[g])
         );
         rtc_alarm_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (hit[g] & pulse_ok),
            .run_i    (alarm_en_i[g] & pulse_ok),
            .active_o (pulse_act[g])
         );
      end
   endgenerate

   assign want_assert = pulse_mode_i ? (|pulse_act) : (|status_o);

   rtc_alarm_pin #(.ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_pin (
      .assert_i    (want_assert),
      .fout_en_i   (fout_en_i),
      .fout_wave_i (fout_wave_i),
      .pin_o       (irq_o)
   );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
   parameter int unsigned NUM_ALARMS     = 2,
   parameter bit          IRQ_ACTIVE_LOW = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_ALARMS-1:0] match_i,
   input logic [NUM_ALARMS-1:0] alarm_en_i,
   input logic                  pulse_mode_i,
   input logic                  fout_en_i,
   input logic                  fout_wave_i,
   input logic                  clr_we_i,
   input logic [NUM_ALARMS-1:0] clr_mask_i,
   input logic [NUM_ALARMS-1:0] status_o,
   input logic                  irq_o
);
   logic on_lvl;
   assign on_lvl = ~IRQ_ACTIVE_LOW;

   generate
      for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_bit
         // R2 and R5: an enabled match always wins
         a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            (match_i[i] && alarm_en_i[i]) |=> status_o[i]);
         a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!(match_i[i] && alarm_en_i[i]) && !status_o[i]) |=> !status_o[i]);
         a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_mask_i[i] && !(match_i[i] && alarm_en_i[i])) |=> !status_o[i]);
         a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[i] && !(clr_we_i && clr_mask_i[i])) |=> status_o[i]);
      end
   endgenerate

   a_r3_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode_i && !fout_en_i && (|status_o)) |-> (irq_o == on_lvl));
   a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse_mode_i && !fout_en_i && (status_o == '0)) |-> (irq_o != on_lvl));
   a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode_i && !fout_en_i && (|(match_i & alarm_en_i)))
      |=> (fout_en_i || !pulse_mode_i || (alarm_en_i == '0) || (irq_o == on_lvl)));
   a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_mode_i && !fout_en_i && (alarm_en_i == '0)) |-> (irq_o != on_lvl));
   a_r9_fout_pass: assert property (@(posedge clk) disable iff (!rst_n)
      fout_en_i |-> (irq_o == fout_wave_i));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
   .NUM_ALARMS(NUM_ALARMS),
   .IRQ_ACTIVE_LOW(IRQ_ACTIVE_LOW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .match_i      (match_i),
   .alarm_en_i   (alarm_en_i),
   .pulse_mode_i (pulse_mode_i),
   .fout_en_i    (fout_en_i),
   .fout_wave_i  (fout_wave_i),
   .clr_we_i     (clr_we_i),
   .clr_mask_i   (clr_mask_i),
   .status_o     (status_o),
   .irq_o        (irq_o)
);

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] match = '0;
   logic [1:0] en = '0;
   logic       pmode = 1'b0;
   logic       fen = 1'b0;
   logic       fwave = 1'b0;
   logic       clr_we = 1'b0;
   logic [1:0] clr_mask = '0;
   logic [1:0] status;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rtc_alarm_irq #(.NUM_ALARMS(2), .PULSE_CYCLES(P)) uut (
      .clk(clk), .rst_n(rst_n), .match_i(match), .alarm_en_i(en),
      .pulse_mode_i(pmode), .fout_en_i(fen), .fout_wave_i(fwave),
      .clr_we_i(clr_we), .clr_mask_i(clr_mask), .status_o(status), .irq_o(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic do_reset();
      match = '0; en = '0; pmode = 0; fen = 0; fwave = 0; clr_we = 0; clr_mask = '0;
      rst_n = 0;
      cyc(); cyc();
      rst_n = 1;
      cyc();
   endtask

   task automatic set_flags(input logic [1:0] m);
      match = m; cyc(); match = '0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 status", status, 0);
      chk("R1 irq", irq, 1);
   endtask

   task automatic t_disabled();
      do_reset();
      en = 2'b01;
      set_flags(2'b10);
      chk("R2 disabled match flag", status, 0);
      chk("R2 disabled match pin", irq, 1);
      set_flags(2'b01);
      chk("R2 enabled match flag", status, 1);
   endtask

   task automatic t_single();
      int low = 0;
      do_reset();
      en = 2'b11;
      for (int c = 0; c < 8; c++) begin
         match = (c == 0) ? 2'b01 : 2'b00;
         cyc();
         if (!irq) low++;
      end
      chk("R3 latched low cycles", low, 8);
      chk("R3 status after match", status, 1);
   endtask

   task automatic t_clear();
      do_reset();
      en = 2'b11;
      set_flags(2'b11);
      chk("R2 both flags", status, 3);
      clr_we = 1; clr_mask = 2'b01; cyc(); clr_we = 0; clr_mask = '0;
      chk("R4 partial clear", status, 2);
      chk("R4 pin held by other flag", irq, 0);
      clr_we = 1; clr_mask = 2'b10; cyc(); clr_we = 0; clr_mask = '0;
      chk("R4 all clear", status, 0);
      chk("R4 pin released", irq, 1);
      set_flags(2'b10);
      chk("R3 re-arm after clear", irq, 0);
   endtask

   task automatic t_clear_race();
      do_reset();
      en = 2'b11;
      set_flags(2'b01);
      match = 2'b01; clr_we = 1; clr_mask = 2'b11; cyc();
      match = '0; clr_we = 0; clr_mask = '0;
      chk("R5 match beats clear", status, 1);
      chk("R5 pin stays low", irq, 0);
   endtask

   task automatic t_pulse_one();
      int low = 0;
      do_reset();
      en = 2'b01; pmode = 1;
      for (int c = 0; c < 10; c++) begin
         match = (c == 0) ? 2'b01 : 2'b00;
         cyc();
         if (!irq) low++;
      end
      chk("R6 pulse length", low, P);
      chk("R6 flag recorded", status, 1);
      chk("R6 pin idle with flag set", irq, 1);
   endtask

   task automatic t_pulse_repeat();
      int low = 0;
      do_reset();
      en = 2'b01; pmode = 1;
      for (int c = 0; c < 14; c++) begin
         match = (c == 0 || c == 7) ? 2'b01 : 2'b00;
         cyc();
         if (!irq) low++;
      end
      chk("R6 repeat without clear", low, 2 * P);
   endtask

   task automatic t_pulse_both();
      int low = 0;
      do_reset();
      en = 2'b11; pmode = 1;
      for (int c = 0; c < 12; c++) begin
         match = (c == 0) ? 2'b11 : ((c == 2) ? 2'b10 : 2'b00);
         cyc();
         if (!irq) low++;
      end
      chk("R7 independent timers", low, P + 2);
      chk("R7 both flags", status, 3);
   endtask

   task automatic t_pulse_stop();
      int low = 0;
      do_reset();
      en = 2'b01; pmode = 1;
      for (int c = 0; c < 10; c++) begin
         match = (c == 0 || c == 5) ? 2'b01 : 2'b00;
         if (c == 2) en = 2'b00;
         cyc();
         if (!irq) low++;
      end
      chk("R8 disable cuts pulse", low, 2);
      en = 2'b01; pmode = 0; pmode = 1;
      cyc();
      chk("R8 no stale pulse", irq, 1);
   endtask

   task automatic t_fout();
      int low = 0;
      do_reset();
      en = 2'b01; pmode = 1; fen = 1; fwave = 1;
      #1;
      chk("R9 pass high", irq, 1);
      fwave = 0;
      #1;
      chk("R9 pass low", irq, 0);
      fwave = 1;
      set_flags(2'b01);
      chk("R9 pulse suppressed", irq, 1);
      chk("R9 flag still set", status, 1);
      fen = 0;
      for (int c = 0; c < 6; c++) begin
         cyc();
         if (!irq) low++;
      end
      chk("R9 nothing pending", low, 0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_disabled();
      t_single();
      t_clear();
      t_clear_race();
      t_pulse_one();
      t_pulse_repeat();
      t_pulse_both();
      t_pulse_stop();
      t_fout();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule